// File: doc/BRIEF.md
# Configuration Readback Serial Streamer

This block dumps a snapshot of configuration frames onto one serial data line. The line advances on each rising edge of a dedicated readback clock. Once configuration has finished, a High trigger level starts a dump. A read-in-progress flag then stays High for the whole stream. The block fetches each frame through a synchronous read port, one word per frame, and parks it in a local frame store that shifts out one bit per clock.

Each frame is framed the same way: a Low start bit, then the data bits, then four check positions that are always High. The stream opens with a short run of High filler bits. It closes with one more Low start bit and an 11-bit CRC signature. Some bit positions are forced High whatever the stored content. The data line idles High whenever no dump is running.

Top module: `rbk_stream`

## Requirements
- R1: After synchronous reset, `rip` is 0, `dout` is 1 and `rd_en` is 0.
- R2: When `trig` is sampled High at a clock edge while `cfg_done` is 1, the block is armed and no dump is running, `rip` is 1 right after that edge.
- R3: While `cfg_done` is 0, a `trig` pulse starts no dump: `rip` stays 0 and `dout` stays 1.
- R4: Each later edge puts one bit on `dout`. The stream is five 1s, then for each frame f, counting up from 0: a 0 start bit, the FRAME_BITS data bits of word f least significant bit first and not inverted, then four check bits.
- R5: The first two data bits of frame 0 (word bits 0 and 1) are sent as 1 whatever is stored.
- R6: The four check bits that close every frame are sent as 1.
- R7: The last seven bits of the final frame are sent as 1. These are the last three data bits (word bits FRAME_BITS-3 to FRAME_BITS-1) and its four check bits.
- R8: After the final frame the block sends one 0 start bit, then the CRC most significant bit first. The CRC is an 11-bit register cleared at dump start. For each frame bit b it updates as c = {c[9:0],0} ^ (c[10]^b ? POLY : 0). Frame bits are the start bits, data bits and check bits of every frame, as sent. POLY defaults to 11'h385.
- R9: `rip` stays 1 while all 5+NUM_FRAMES*(FRAME_BITS+5)+12 bits are sent. On the edge after the last CRC bit, `rip` returns to 0 and `dout` returns to 1.
- R10: A `trig` held High, or raised again, during a dump starts nothing new. The next dump needs `trig` to be sampled Low and then High after `rip` has dropped.
- R11: `rd_en` is High for exactly one cycle per frame, in frame order, with `rd_addr` equal to the frame index. Read data is taken on `rd_data` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readback clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Configuration has completed |
| trig | input | 1 | Level that requests a dump |
| rip | output | 1 | Read in progress |
| dout | output | 1 | Serial readback data |
| rd_en | output | 1 | Frame read strobe |
| rd_addr | output | $clog2(NUM_FRAMES) | Frame index being read |
| rd_data | input | FRAME_BITS | Frame word, valid one cycle after rd_en |

## Verification
The assertions assume the read port returns a word exactly one cycle after `rd_en`. They also assume `trig` and `cfg_done` are synchronous to the readback clock, with reset held until both are at defined levels. The bench models the frame store as a registered memory with that latency. It drives every input on the falling edge and lowers `trig` for at least one cycle before each intended dump. The exception is the deliberate hold scenario, which checks that a held level is ignored.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

    localparam int DUMMY_BITS = 5;
    localparam int CHECK_BITS = 4;
    localparam int CRC_W      = 11;
    localparam int TAIL_HIGH  = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DUMMY,
        PH_FSTART,
        PH_DATA,
        PH_CHECK,
        PH_ESTART,
        PH_CRC,
        PH_TAIL
    } rbk_phase_e;

    typedef struct packed {
        logic bit_val;
        logic crc_acc;
        logic crc_sh;
        logic fs_load;
        logic fs_shift;
    } rbk_step_t;

    function automatic logic [CRC_W-1:0] crc_next(
        input logic [CRC_W-1:0] c,
        input logic             b,
        input logic [CRC_W-1:0] poly
    );
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/rbk_arm.sv
module rbk_arm (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic cfg_done,
    input  logic busy,
    output logic start
);
    logic armed;

    assign start = armed && trig && cfg_done && !busy;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (start)
            armed <= 1'b0;
        else if (!busy && !trig)
            armed <= 1'b1;
    end
endmodule

// File: rtl/rbk_crc.sv
module rbk_crc
    import rbk_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 11'h385
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic acc,
    input  logic sh,
    input  logic din,
    output logic msb
);
    logic [CRC_W-1:0] crc_q;

    assign msb = crc_q[CRC_W-1];

    always_ff @(posedge clk) begin
        if (rst || clr)
            crc_q <= '0;
        else if (acc)
            crc_q <= crc_next(crc_q, din, POLY);
        else if (sh)
            crc_q <= {crc_q[CRC_W-2:0], 1'b0};
    end
endmodule

// File: rtl/rbk_fstore.sv
module rbk_fstore #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         lsb
);
    logic [W-1:0] word_q;

    assign lsb = word_q[0];

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (load)
            word_q <= din >> 1;
        else if (shift)
            word_q <= word_q >> 1;
    end
endmodule

// File: rtl/rbk_stream.sv
module rbk_stream
    import rbk_pkg::*;
#(
    parameter int               NUM_FRAMES = 4,
    parameter int               FRAME_BITS = 16,
    parameter logic [CRC_W-1:0] CRC_POLY   = 11'h385,
    localparam int              AW         = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_done,
    input  logic                  trig,
    output logic                  rip,
    output logic                  dout,
    output logic                  rd_en,
    output logic [AW-1:0]         rd_addr,
    input  logic [FRAME_BITS-1:0] rd_data
);
    localparam int MAXC = (FRAME_BITS > CRC_W) ? FRAME_BITS : CRC_W;
    localparam int CW   = $clog2(MAXC);

    localparam logic [CW-1:0] C_DUMMY_END = CW'(DUMMY_BITS - 1);
    localparam logic [CW-1:0] C_DATA_END  = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] C_CHECK_END = CW'(CHECK_BITS - 1);
    localparam logic [CW-1:0] C_CRC_END   = CW'(CRC_W - 1);
    localparam logic [CW-1:0] C_HEAD_HIGH = CW'(2);
    localparam logic [CW-1:0] C_TAIL_FROM = CW'(FRAME_BITS - (TAIL_HIGH - CHECK_BITS));
    localparam logic [AW-1:0] LAST_FRM    = AW'(NUM_FRAMES - 1);

    rbk_phase_e      phase_q, phase_n;
    logic [CW-1:0]   cnt_q, cnt_n;
    logic [AW-1:0]   frm_q, frm_n;
    logic            dout_q;
    rbk_step_t       step;
    logic            start;
    logic            crc_msb;
    logic            fs_lsb;
    logic            raw_bit;
    logic            forced;

    rbk_arm u_arm (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig),
        .cfg_done (cfg_done),
        .busy     (rip),
        .start    (start)
    );

    rbk_crc #(.POLY(CRC_POLY)) u_crc (
        .clk (clk),
        .rst (rst),
        .clr (start),
        .acc (step.crc_acc),
        .sh  (step.crc_sh),
        .din (step.bit_val),
        .msb (crc_msb)
    );

    rbk_fstore #(.W(FRAME_BITS)) u_fs (
        .clk   (clk),
        .rst   (rst),
        .load  (step.fs_load),
        .shift (step.fs_shift),
        .din   (rd_data),
        .lsb   (fs_lsb)
    );

    assign raw_bit = (cnt_q == '0) ? rd_data[0] : fs_lsb;
    assign forced  = ((frm_q == '0) && (cnt_q < C_HEAD_HIGH)) ||
                     ((frm_q == LAST_FRM) && (cnt_q >= C_TAIL_FROM));

    always_comb begin
        phase_n = phase_q;
        cnt_n   = cnt_q;
        frm_n   = frm_q;
        step    = '{bit_val: 1'b1, crc_acc: 1'b0, crc_sh: 1'b0,
                    fs_load: 1'b0, fs_shift: 1'b0};
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_n = PH_DUMMY;
                    cnt_n   = '0;
                    frm_n   = '0;
                end
            end
            PH_DUMMY: begin
                if (cnt_q == C_DUMMY_END) begin
                    phase_n = PH_FSTART;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            PH_FSTART: begin
                step.bit_val = 1'b0;
                step.crc_acc = 1'b1;
                phase_n      = PH_DATA;
                cnt_n        = '0;
            end
            PH_DATA: begin
                step.bit_val  = forced | raw_bit;
                step.crc_acc  = 1'b1;
                step.fs_load  = (cnt_q == '0);
                step.fs_shift = (cnt_q != '0);
                if (cnt_q == C_DATA_END) begin
                    phase_n = PH_CHECK;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            PH_CHECK: begin
                step.crc_acc = 1'b1;
                if (cnt_q == C_CHECK_END) begin
                    cnt_n = '0;
                    if (frm_q == LAST_FRM) begin
                        phase_n = PH_ESTART;
                    end else begin
                        phase_n = PH_FSTART;
                        frm_n   = frm_q + 1'b1;
                    end
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            PH_ESTART: begin
                step.bit_val = 1'b0;
                phase_n      = PH_CRC;
                cnt_n        = '0;
            end
            PH_CRC: begin
                step.bit_val = crc_msb;
                step.crc_sh  = 1'b1;
                if (cnt_q == C_CRC_END) begin
                    phase_n = PH_TAIL;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            PH_TAIL: begin
                phase_n = PH_IDLE;
            end
            default: phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            frm_q   <= '0;
            dout_q  <= 1'b1;
        end else begin
            phase_q <= phase_n;
            cnt_q   <= cnt_n;
            frm_q   <= frm_n;
            dout_q  <= step.bit_val;
        end
    end

    assign rip     = (phase_q != PH_IDLE);
    assign dout    = dout_q;
    assign rd_en   = (phase_q == PH_FSTART);
    assign rd_addr = frm_q;

endmodule

// File: rtl/rbk_stream_chk.sv
module rbk_stream_chk #(
    parameter int NUM_FRAMES = 4,
    parameter int AW         = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_done,
    input logic          trig,
    input logic          rip,
    input logic          dout,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr
);
    AST_RIP_NEEDS_TRIG: assert property (@(posedge clk) disable iff (rst)
        $rose(rip) |-> ($past(trig) && $past(cfg_done))); // R2

    AST_NO_START_UNCONFIGURED: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |=> !$rose(rip)); // R3

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !dout); // R4

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !rip |-> dout); // R9

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        $fell(rip) |=> !rip); // R10

    AST_READ_IN_DUMP: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rip && (int'(rd_addr) < NUM_FRAMES))); // R11

    AST_READ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en); // R11
endmodule

bind rbk_stream rbk_stream_chk #(.NUM_FRAMES(NUM_FRAMES), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_done (cfg_done),
    .trig     (trig),
    .rip      (rip),
    .dout     (dout),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr)
);

// File: tb/sim_rbk_stream.sv
module sim_rbk_stream;
    localparam int          NF   = 4;
    localparam int          FB   = 16;
    localparam logic [10:0] POLY = 11'h385;
    localparam int          AW   = $clog2(NF);
    localparam int          L    = 5 + NF * (FB + 5) + 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_done = 1'b0;
    logic          trig = 1'b0;
    logic          rip, dout, rd_en;
    logic [AW-1:0] rd_addr;
    logic [FB-1:0] rd_data = '0;

    logic [FB-1:0] mem [NF];
    logic          exp_bits [L];
    logic          got_bits [L];
    int            rd_log [16];
    int            rd_cnt = 0;
    int            total = 0;
    int            bad = 0;

    always #2 clk = ~clk;

    rbk_stream #(.NUM_FRAMES(NF), .FRAME_BITS(FB), .CRC_POLY(POLY)) u0 (
        .clk(clk), .rst(rst), .cfg_done(cfg_done), .trig(trig),
        .rip(rip), .dout(dout), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
            if (rd_cnt < 16) rd_log[rd_cnt] = int'(rd_addr);
            rd_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic build_expected();
        int          idx;
        logic [10:0] c;
        logic        v;
        idx = 0;
        c   = '0;
        for (int i = 0; i < 5; i++) begin exp_bits[idx] = 1'b1; idx++; end
        for (int f = 0; f < NF; f++) begin
            exp_bits[idx] = 1'b0; idx++;
            c = {c[9:0], 1'b0} ^ ((c[10] ^ 1'b0) ? POLY : 11'h0);
            for (int b = 0; b < FB; b++) begin
                v = mem[f][b];
                if ((f == 0 && b < 2) || (f == NF - 1 && b >= FB - 3)) v = 1'b1;
                exp_bits[idx] = v; idx++;
                c = {c[9:0], 1'b0} ^ ((c[10] ^ v) ? POLY : 11'h0);
            end
            for (int k = 0; k < 4; k++) begin
                exp_bits[idx] = 1'b1; idx++;
                c = {c[9:0], 1'b0} ^ ((c[10] ^ 1'b1) ? POLY : 11'h0);
            end
        end
        exp_bits[idx] = 1'b0; idx++;
        for (int k = 10; k >= 0; k--) begin exp_bits[idx] = c[k]; idx++; end
    endtask

    function automatic string tag_of(input int k);
        int p;
        int f;
        int b;
        if (k < 5) return "R4 dummy";
        p = k - 5;
        if (p >= NF * (FB + 5)) return "R8 end start/crc";
        f = p / (FB + 5);
        b = p % (FB + 5);
        if (b == 0) return "R4 start bit";
        if (b > FB) return (f == NF - 1) ? "R7 final check" : "R6 check bit";
        if (f == 0 && b <= 2) return "R5 head forced";
        if (f == NF - 1 && b > FB - 3) return "R7 tail forced";
        return "R4 data bit";
    endfunction

    // run one dump; when hold is set trig stays High through it
    task automatic run_dump(input bit hold);
        build_expected();
        rd_cnt = 0;
        @(negedge clk) trig = 1'b1;
        @(posedge clk); #1;
        chk(rip === 1'b1, "R2 rip rise", int'(rip), 1);
        if (!hold) begin @(negedge clk) trig = 1'b0; end
        for (int k = 0; k < L; k++) begin
            if (k > 0 || hold) @(posedge clk);
            else @(posedge clk);
            #1;
            got_bits[k] = dout;
            chk(rip === 1'b1, "R9 rip held", int'(rip), 1);
            chk(dout === exp_bits[k], tag_of(k), int'(dout), int'(exp_bits[k]));
        end
        @(posedge clk); #1;
        chk(rip === 1'b0, "R9 rip drop", int'(rip), 0);
        chk(dout === 1'b1, "R9 idle high", int'(dout), 1);
        chk(rd_cnt == NF, "R11 read count", rd_cnt, NF);
        for (int f = 0; f < NF; f++)
            chk(rd_log[f] == f, "R11 read order", rd_log[f], f);
    endtask

    task automatic t_reset();
        #1;
        chk(rip === 1'b0, "R1 rip", int'(rip), 0);
        chk(dout === 1'b1, "R1 dout", int'(dout), 1);
        chk(rd_en === 1'b0, "R1 rd_en", int'(rd_en), 0);
    endtask

    task automatic t_unconfigured();
        @(negedge clk) trig = 1'b1;
        repeat (3) @(negedge clk);
        trig = 1'b0;
        repeat (6) begin
            @(negedge clk);
            chk(rip === 1'b0, "R3 no dump", int'(rip), 0);
            chk(dout === 1'b1, "R3 line idle", int'(dout), 1);
        end
    endtask

    task automatic t_pattern();
        for (int f = 0; f < NF; f++) mem[f] = 16'hA5C3 ^ (16'h1357 * 16'(f + 1));
        run_dump(1'b0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_zeros_ones();
        for (int f = 0; f < NF; f++) mem[f] = '0;
        run_dump(1'b0);
        repeat (3) @(negedge clk);
        for (int f = 0; f < NF; f++) mem[f] = '1;
        run_dump(1'b0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_hold();
        for (int f = 0; f < NF; f++) mem[f] = 16'h0F0F << f;
        run_dump(1'b1);
        repeat (8) begin
            @(negedge clk);
            chk(rip === 1'b0, "R10 held trig ignored", int'(rip), 0);
        end
        trig = 1'b0;
        @(negedge clk);
        run_dump(1'b0);
    endtask

    initial begin
        for (int f = 0; f < NF; f++) mem[f] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_unconfigured();
        cfg_done = 1'b1;
        repeat (2) @(negedge clk);
        t_pattern();
        t_zeros_ones();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule